// File: doc/BRIEF.md
# HSYNC Width Classifier with Low Frame-Rate Flag

This block belongs to a display sync processor. It synchronises the incoming horizontal sync line to the system clock and counts how many clock cycles each high pulse lasts. It then labels the pulse as long, short, or inside the dead band between the two limits. A two-bit window field chooses one of three limit pairs. The most recent decisive label sets a polarity output: a short high pulse means positive sync, and a long one means negative sync.

The same slice watches a vertical frame period count that another block supplies. When that count goes above 0xC00, the frame rate has dropped below roughly 40.7 Hz, and a sticky status bit is set. Software can only clear this bit. An enable bit gates it onto an interrupt request line.

A single 8-bit register, with a write strobe and an always-valid read bus, holds the status bit, the enable and the window field. All time limits are parameters given in tenths of a microsecond. They are converted to clock ticks at elaboration using the clock frequency parameter, which defaults to 24 MHz.

Top module: `sync_width_classifier`

## Requirements
- R1: After reset, rd_data is 0, irq is 0, hs_polarity is 1, and hs_long and hs_short are both 0.
- R2: A high pulse of N cycles on hsync_in is measured as width N. The result shows as a one-cycle pulse on hs_long or hs_short in the third clock edge's output after the first edge that samples hsync_in low. The two pulses are never both high.
- R3: With window field 00, a width above 168 ticks (7 µs) is long and a width below 144 ticks (6 µs) is short.
- R4: With window field 01, a width above 336 ticks (14 µs) is long and a width below 288 ticks (12 µs) is short.
- R5: With window field 10 or 11, a width above 84 ticks (3.5 µs) is long and a width below 72 ticks (3 µs) is short.
- R6: A width inside the dead band, which includes both limits, raises neither hs_long nor hs_short and leaves hs_polarity unchanged.
- R7: A width counter that saturates at 1023 cycles reports the pulse as long.
- R8: hs_polarity is 1 after a short classification and 0 after a long one.
- R9: The flag, which is register bit 0, sets on the edge after vfr_period exceeds 0xC00. A value of exactly 0xC00 does not set it.
- R10: The flag is sticky. A write with bit 0 at 0 clears it, and a write with bit 0 at 1 has no effect. When a set condition and a clearing write happen in the same cycle, the flag stays set.
- R11: irq is high exactly while the flag and the enable (register bit 1) are both 1.
- R12: The register holds the window field in bits 3:2 and the enable in bit 1, both loaded on every write. Bits 7:4 read 0 and ignore what is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync line, asynchronous to clk |
| vfr_period | input | 16 | Vertical frame period count from the frame counter |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interrupt request for a low frame rate |
| hs_polarity | output | 1 | 1 = positive sync, 0 = negative sync |
| hs_long | output | 1 | One-cycle pulse: the last high pulse was long |
| hs_short | output | 1 | One-cycle pulse: the last high pulse was short |

## Verification
The assertions assume that hsync_in, vfr_period, wr_en and wr_data change only away from the rising clock edge. They also assume vfr_period is a plain level that may be sampled on any cycle, not only at frame boundaries. The bench changes every input at the falling edge, so each value is stable well before it is sampled. Each sync pulse is followed by an idle gap of several cycles, so one classification has completed before the next pulse begins.

// File: rtl/swc_pkg.sv
package swc_pkg;

  // register bit positions
  localparam int unsigned BIT_FLAG = 0;
  localparam int unsigned BIT_EN   = 1;
  localparam int unsigned WIN_LSB  = 2;

  typedef struct packed {
    int unsigned long_lim;
    int unsigned short_lim;
  } swc_limits_t;

  // tenths of a microsecond to clock ticks
  function automatic int unsigned x10_to_ticks(input int unsigned x10_us,
                                               input int unsigned clk_khz);
    return (x10_us * clk_khz) / 10000;
  endfunction

  // window 00: middle, 01: slow, 1x: fast
  function automatic swc_limits_t pick_limits(input logic [1:0] win,
                                              input int unsigned mid_l,
                                              input int unsigned mid_s,
                                              input int unsigned slow_l,
                                              input int unsigned slow_s,
                                              input int unsigned fast_l,
                                              input int unsigned fast_s);
    swc_limits_t r;
    if (win[1]) begin
      r.long_lim  = fast_l;
      r.short_lim = fast_s;
    end else if (win[0]) begin
      r.long_lim  = slow_l;
      r.short_lim = slow_s;
    end else begin
      r.long_lim  = mid_l;
      r.short_lim = mid_s;
    end
    return r;
  endfunction

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/swc_width_meter.sv
module swc_width_meter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  output logic             done,
  output logic [CNT_W-1:0] width,
  output logic             saturated
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (rise) begin
      cnt <= CNT_W'(1);
    end else if (level && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done      = fall;
  assign width     = cnt;
  assign saturated = (cnt == CNT_MAX);
endmodule

// File: rtl/swc_classifier.sv
module swc_classifier #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned MID_L  = 168,
  parameter int unsigned MID_S  = 144,
  parameter int unsigned SLOW_L = 336,
  parameter int unsigned SLOW_S = 288,
  parameter int unsigned FAST_L = 84,
  parameter int unsigned FAST_S = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] width,
  input  logic             saturated,
  input  logic [1:0]       win,
  output logic             ev_long,
  output logic             ev_short,
  output logic             polarity
);
  swc_pkg::swc_limits_t lim;
  logic is_long, is_short, last_long;

  always_comb begin
    lim      = swc_pkg::pick_limits(win, MID_L, MID_S, SLOW_L, SLOW_S, FAST_L, FAST_S);
    is_long  = saturated || (32'(width) > lim.long_lim);
    is_short = !saturated && (32'(width) < lim.short_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_long   <= 1'b0;
      ev_short  <= 1'b0;
      last_long <= 1'b0;
    end else begin
      ev_long  <= 1'b0;
      ev_short <= 1'b0;
      if (done) begin
        if (is_long) begin
          ev_long   <= 1'b1;
          last_long <= 1'b1;
        end else if (is_short) begin
          ev_short  <= 1'b1;
          last_long <= 1'b0;
        end
      end
    end
  end

  assign polarity = ~last_long;
endmodule

// File: rtl/swc_lowv_ctrl.sv
module swc_lowv_ctrl #(
  parameter int unsigned VFR_W     = 16,
  parameter int unsigned VFR_LIMIT = 32'h0000_0C00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VFR_W-1:0] vfr,
  input  logic             wr_en,
  input  logic [3:0]       wr_bits,
  output logic             flag,
  output logic             en,
  output logic [1:0]       win,
  output logic             irq,
  output logic             set_evt
);
  logic clr_wr;

  assign set_evt = (32'(vfr) > VFR_LIMIT);
  assign clr_wr  = wr_en && !wr_bits[swc_pkg::BIT_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      en   <= 1'b0;
      win  <= 2'b00;
    end else begin
      if (set_evt)     flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
      if (wr_en) begin
        en  <= wr_bits[swc_pkg::BIT_EN];
        win <= wr_bits[swc_pkg::WIN_LSB +: 2];
      end
    end
  end

  assign irq = flag & en;
endmodule

// File: rtl/sync_width_classifier.sv
module sync_width_classifier #(
  parameter int unsigned CLK_KHZ      = 24000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned VFR_W        = 16,
  parameter int unsigned VFR_LIMIT    = 32'h0000_0C00,
  parameter int unsigned MID_LONG_X10  = 70,
  parameter int unsigned MID_SHORT_X10 = 60,
  parameter int unsigned SLOW_LONG_X10 = 140,
  parameter int unsigned SLOW_SHORT_X10 = 120,
  parameter int unsigned FAST_LONG_X10 = 35,
  parameter int unsigned FAST_SHORT_X10 = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic [VFR_W-1:0] vfr_period,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             irq,
  output logic             hs_polarity,
  output logic             hs_long,
  output logic             hs_short
);
  localparam int unsigned MID_L  = swc_pkg::x10_to_ticks(MID_LONG_X10, CLK_KHZ);
  localparam int unsigned MID_S  = swc_pkg::x10_to_ticks(MID_SHORT_X10, CLK_KHZ);
  localparam int unsigned SLOW_L = swc_pkg::x10_to_ticks(SLOW_LONG_X10, CLK_KHZ);
  localparam int unsigned SLOW_S = swc_pkg::x10_to_ticks(SLOW_SHORT_X10, CLK_KHZ);
  localparam int unsigned FAST_L = swc_pkg::x10_to_ticks(FAST_LONG_X10, CLK_KHZ);
  localparam int unsigned FAST_S = swc_pkg::x10_to_ticks(FAST_SHORT_X10, CLK_KHZ);

  // named internal events, observed by the checker
  logic             hs_level, rise_evt, fall_evt;
  logic             meas_done, meas_sat;
  logic [CNT_W-1:0] meas_width;
  logic             lowv_flag, lowv_en, lowv_set;
  logic [1:0]       win_sel;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[7:4];

  swc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(hsync_in),
    .level(hs_level), .rise(rise_evt), .fall(fall_evt)
  );

  swc_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .level(hs_level), .rise(rise_evt), .fall(fall_evt),
    .done(meas_done), .width(meas_width), .saturated(meas_sat)
  );

  swc_classifier #(
    .CNT_W(CNT_W), .MID_L(MID_L), .MID_S(MID_S), .SLOW_L(SLOW_L),
    .SLOW_S(SLOW_S), .FAST_L(FAST_L), .FAST_S(FAST_S)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .done(meas_done), .width(meas_width),
    .saturated(meas_sat), .win(win_sel),
    .ev_long(hs_long), .ev_short(hs_short), .polarity(hs_polarity)
  );

  swc_lowv_ctrl #(.VFR_W(VFR_W), .VFR_LIMIT(VFR_LIMIT)) u_lowv (
    .clk(clk), .rst_n(rst_n), .vfr(vfr_period), .wr_en(wr_en),
    .wr_bits(wr_data[3:0]), .flag(lowv_flag), .en(lowv_en), .win(win_sel),
    .irq(irq), .set_evt(lowv_set)
  );

  always_comb begin
    rd_data = 8'h00;
    rd_data[swc_pkg::BIT_FLAG]        = lowv_flag;
    rd_data[swc_pkg::BIT_EN]          = lowv_en;
    rd_data[swc_pkg::WIN_LSB +: 2]    = win_sel;
  end
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int unsigned VFR_W     = 16,
  parameter int unsigned VFR_LIMIT = 32'h0000_0C00
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_evt,
  input logic             hs_long,
  input logic             hs_short,
  input logic             hs_polarity,
  input logic             irq,
  input logic             lowv_flag,
  input logic             lowv_en,
  input logic [VFR_W-1:0] vfr_period,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data
);
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_long && hs_short));

  assert_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_long || hs_short) |-> $past(fall_evt));

  assert_long_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_long |-> !hs_polarity);

  assert_short_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_short |-> hs_polarity);

  assert_pol_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_long && !hs_short) |-> $stable(hs_polarity));

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(vfr_period) > VFR_LIMIT) |=> lowv_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lowv_flag && !(wr_en && !wr_data[0])) |=> lowv_flag);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lowv_flag && wr_en && !wr_data[0] && !(32'(vfr_period) > VFR_LIMIT)) |=> !lowv_flag);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (lowv_flag && lowv_en));

  assert_irq_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lowv_flag && lowv_en) |-> irq);

  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0);
endmodule

bind sync_width_classifier swc_checker #(.VFR_W(VFR_W), .VFR_LIMIT(VFR_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .hs_long(hs_long),
  .hs_short(hs_short), .hs_polarity(hs_polarity), .irq(irq),
  .lowv_flag(lowv_flag), .lowv_en(lowv_en), .vfr_period(vfr_period),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/sync_width_classifier_bench.sv
module sync_width_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SAT_MAX    = 1023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync_in = 1'b0;
  logic [15:0] vfr_period = 16'h0100;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        irq, hs_polarity, hs_long, hs_short;

  int checks = 0;
  int errors = 0;
  bit compare_on = 1'b0;
  bit seen_long = 1'b0, seen_short = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_width_classifier u_sync_width_classifier (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vfr_period(vfr_period),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .hs_polarity(hs_polarity), .hs_long(hs_long), .hs_short(hs_short)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_run = 0;
  int pend_w[$];
  int pend_d[$];
  int m_flag = 0, m_en = 0, m_win = 0, m_pol = 1, m_long = 0, m_short = 0;

  function automatic int lim_long(input int w);
    if (w >= 2) return 84;
    if (w == 1) return 336;
    return 168;
  endfunction
  function automatic int lim_short(input int w);
    if (w >= 2) return 72;
    if (w == 1) return 288;
    return 144;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; pend_w.delete(); pend_d.delete();
      m_flag = 0; m_en = 0; m_win = 0; m_pol = 1; m_long = 0; m_short = 0;
    end else begin
      m_long = 0; m_short = 0;
      foreach (pend_d[i]) pend_d[i]--;
      if (pend_d.size() > 0 && pend_d[0] == 0) begin
        int w;
        w = pend_w.pop_front();
        void'(pend_d.pop_front());
        if (w >= SAT_MAX || w > lim_long(m_win)) begin
          m_long = 1; m_pol = 0;
        end else if (w < lim_short(m_win)) begin
          m_short = 1; m_pol = 1;
        end
      end
      if (hsync_in) m_run++;
      else if (m_run > 0) begin
        pend_w.push_back(m_run); pend_d.push_back(2); m_run = 0;
      end
      if (vfr_period > 16'h0C00) m_flag = 1;
      else if (wr_en && !wr_data[0]) m_flag = 0;
      if (wr_en) begin
        m_en = wr_data[1];
        m_win = wr_data[3:2];
      end
    end
  end

  always @(negedge clk) begin
    if (hs_long) seen_long = 1'b1;
    if (hs_short) seen_short = 1'b1;
    if (compare_on) begin
      chk("R2 hs_long", hs_long, m_long);
      chk("R2 hs_short", hs_short, m_short);
      chk("R8 polarity", hs_polarity, m_pol);
      chk("R10 flag", rd_data[0], m_flag);
      chk("R12 enable", rd_data[1], m_en);
      chk("R12 window", rd_data[3:2], m_win);
      chk("R12 upper", rd_data[7:4], 0);
      chk("R11 irq", irq, m_flag & m_en);
    end
  end

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // exp: 0 none, 1 short, 2 long
  task automatic pulse(input int w, input int exp, input string tag);
    @(negedge clk);
    seen_long = 1'b0; seen_short = 1'b0;
    hsync_in = 1'b1;
    repeat (w) @(negedge clk);
    hsync_in = 1'b0;
    repeat (6) @(negedge clk);
    chk({tag, " long seen"}, seen_long, exp == 2);
    chk({tag, " short seen"}, seen_short, exp == 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irq", irq, 0);
    chk("R1 polarity", hs_polarity, 1);
    chk("R1 events", hs_long | hs_short, 0);
    compare_on = 1'b1;

    // middle window
    pulse(200, 2, "R3 200");
    pulse(100, 1, "R3 100");
    pulse(169, 2, "R3 169");
    pulse(168, 0, "R6 168");
    chk("R6 pol held", hs_polarity, 0);
    pulse(150, 0, "R6 150");
    pulse(144, 0, "R6 144");
    pulse(143, 1, "R3 143");
    pulse(1, 1, "R3 1");

    // slow window
    reg_write(8'h04);
    pulse(337, 2, "R4 337");
    pulse(336, 0, "R6 336");
    pulse(288, 0, "R6 288");
    pulse(200, 1, "R4 200");
    pulse(300, 0, "R6 300");
    pulse(287, 1, "R4 287");
    pulse(1100, 2, "R7 1100");
    pulse(1023, 2, "R7 1023");

    // fast window, both encodings
    reg_write(8'h08);
    pulse(71, 1, "R5 71");
    pulse(85, 2, "R5 85");
    pulse(84, 0, "R6 84");
    pulse(72, 0, "R6 72");
    reg_write(8'h0C);
    pulse(10, 1, "R5 10");
    pulse(100, 2, "R5 100");

    // low frame-rate flag
    reg_write(8'h00);
    @(negedge clk); vfr_period = 16'h0C00;
    repeat (3) @(negedge clk);
    chk("R9 equal no set", rd_data[0], 0);
    vfr_period = 16'h0C01;
    @(negedge clk);
    chk("R9 set", rd_data[0], 1);
    chk("R11 irq masked", irq, 0);
    vfr_period = 16'h0200;
    reg_write(8'h01);
    chk("R10 write one keeps", rd_data[0], 1);
    reg_write(8'hF3);
    chk("R11 irq on", irq, 1);
    chk("R12 upper ignored", rd_data[7:4], 0);
    @(negedge clk); vfr_period = 16'hFFFF;
    reg_write(8'h02);
    chk("R10 set wins", rd_data[0], 1);
    vfr_period = 16'h0200;
    reg_write(8'h02);
    chk("R10 cleared", rd_data[0], 0);
    chk("R11 irq off", irq, 0);
    repeat (4) @(negedge clk);

    compare_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule